// File: doc/BRIEF.md
# Dual-Channel Timer Output Compare Unit

This block is the compare stage that sits beside an 8-bit timer/counter. Each of its two channels holds a compare value, watches the running count, and drives a match line toward a downstream waveform generator whenever the count equals that value. A match that is seen on a timer tick latches a per-channel compare flag. When that channel's interrupt enable is high, the flag raises an interrupt request. The flag is cleared when the interrupt is acknowledged, or when software writes a one to it.

The compare values are loaded through a small register port. The mode input decides whether the port writes the active compare value directly (normal and clear-on-compare modes) or writes a shadow copy (the two PWM modes). In the PWM modes the shadow copy moves into the active register only at one end of the count: the bottom strobe in one PWM mode and the top strobe in the other. This keeps every pulse whole and symmetric. The counter, the prescaler and the pin logic are outside this block.

Top module: `tmr_ocu`

## Requirements
- R1: `match[i]` is high in exactly the cycles where `count` equals channel i's active compare value. This is combinational, with no delay.
- R2: The flag of channel i is set at a clock edge where `tick_en` and `match[i]` are both high, and can be read from the next cycle on. A match while `tick_en` is low does not set it.
- R3: `irq[i]` is high exactly while flag i is set and `irq_en[i]` is high.
- R4: A high `irq_ack[i]` at a clock edge clears flag i.
- R5: A write to address 2 clears flag i when data bit i is 1. A data bit of 0 leaves that flag unchanged.
- R6: When a hardware set and a clear (by write or by acknowledge) fall on the same edge, the set wins and the flag ends up 1.
- R7: In mode 0 (normal) and mode 1 (clear-on-compare), a write to address i (0 = A, 1 = B) updates channel i's active compare value at that edge.
- R8: In mode 2 and mode 3 (PWM), a write to address i goes only to the shadow register. The shadow moves into the active value at an edge where `tick_en` is high and the mode's strobe is high: `at_bottom` in mode 2, `at_top` in mode 3. The other strobe, or a strobe without `tick_en`, does nothing.
- R9: A read of address i returns the shadow register in modes 2 and 3 and the active value in modes 0 and 1. A read of address 2 returns flag A in bit 0 and flag B in bit 1, with zeros above.
- R10: After a synchronous reset with `rst_n` low, all compare values, shadows and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer clock enable; qualifies flag sets and shadow transfers |
| count | input | 8 | Running counter value |
| at_top | input | 1 | Counter is at its top value |
| at_bottom | input | 1 | Counter is at its bottom value |
| mode | input | 2 | 0 normal, 1 clear-on-compare, 2 PWM (load at bottom), 3 PWM (load at top) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | 0 compare A, 1 compare B, 2 flags |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| irq_en | input | 2 | Per-channel interrupt enable |
| irq_ack | input | 2 | Per-channel interrupt acknowledge; clears the flag |
| match | output | 2 | Per-channel equality with the active compare value |
| irq | output | 2 | Per-channel interrupt request |

## Verification
`match`, `irq` and `cpu_rdata` are combinational. The bench checks them one time step after it changes the inputs, in the same cycle. Flag sets, flag clears, direct compare writes and shadow transfers all take effect at the single clock edge where their cause is present, so each one is observed in the cycle right after that edge. The bench applies each stimulus just after a rising edge, lets exactly one edge pass, and then samples through the read port or `match`. A full sweep of compare values against all count values covers R1 and R7. Short sequences cover the flag and buffering behaviour at the edges where they take effect.

// File: rtl/tmr_ocu_pkg.sv
// Shared types for the timer output compare unit.
// Assumes the mode encoding that the top-level port documents.
package tmr_ocu_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL     = 2'd0,
        MODE_CLR_ON_CMP = 2'd1,
        MODE_PWM_BOTTOM = 2'd2,
        MODE_PWM_TOP    = 2'd3
    } ocu_mode_e;

    // Buffered (shadowed) compare writes apply in both PWM modes.
    function automatic logic mode_buffered(input ocu_mode_e m);
        return (m == MODE_PWM_BOTTOM) || (m == MODE_PWM_TOP);
    endfunction

endpackage

// File: rtl/tmr_ocu_cmpreg.sv
// Compare register with an optional shadow copy.
// Unbuffered: a write loads the active value. Buffered: a write loads the
// shadow, and load_strobe (already qualified by tick) copies it to active.
// If a write and a load fall on the same edge, active takes the old shadow.
module tmr_ocu_cmpreg #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buffered,
    input  logic          load_strobe,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] active,
    output logic [CW-1:0] shadow
);

    // Update the active compare value from a direct write or a shadow transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (wr_en && !buffered) begin
            active <= wr_data;
        end else if (buffered && load_strobe) begin
            active <= shadow;
        end
    end

    // Capture CPU writes into the shadow while buffering is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en && buffered) begin
            shadow <= wr_data;
        end
    end

endmodule

// File: rtl/tmr_ocu_flag.sv
// Sticky compare flag. A set has priority over a clear on the same edge.
module tmr_ocu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Hold the flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_ocu_channel.sv
// One compare channel: a compare register, an equality detector and a flag.
// Assumes that count is stable for the whole cycle and that tick_en marks
// the cycles in which the timer advances.
module tmr_ocu_channel #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          tick_en,
    input  logic          buffered,
    input  logic          load_strobe,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          sw_clr,
    input  logic          ack,
    output logic          match,
    output logic          flag,
    output logic [CW-1:0] active,
    output logic [CW-1:0] shadow
);

    logic flag_set;
    logic flag_clr;

    tmr_ocu_cmpreg #(.CW(CW)) u_cmpreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .buffered   (buffered),
        .load_strobe(load_strobe),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .active     (active),
        .shadow     (shadow)
    );

    // Compare the count with the active value, and derive the flag controls.
    always_comb begin
        match    = (count == active);
        flag_set = tick_en && match;
        flag_clr = sw_clr || ack;
    end

    tmr_ocu_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (flag_set),
        .clr  (flag_clr),
        .flag (flag)
    );

endmodule

// File: rtl/tmr_ocu.sv
// Top level of the output compare unit: NCH channels, the register port
// decode and read mux, and the interrupt gating.
// Address map: 0..NCH-1 hold the compare registers, NCH holds the flags
// (write one to clear). Assumes NCH <= CW so the flags fit in one word.
module tmr_ocu
    import tmr_ocu_pkg::*;
#(
    parameter int CW  = 8,
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic [CW-1:0]  count,
    input  logic           at_top,
    input  logic           at_bottom,
    input  logic [1:0]     mode,
    input  logic           cpu_wr,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [CW-1:0]  cpu_wdata,
    output logic [CW-1:0]  cpu_rdata,
    input  logic [NCH-1:0] irq_en,
    input  logic [NCH-1:0] irq_ack,
    output logic [NCH-1:0] match,
    output logic [NCH-1:0] irq
);

    localparam logic [AW-1:0] FLAG_ADDR = AW'(NCH);

    ocu_mode_e               mode_e;
    logic                    buffered;
    logic                    load_strobe;
    logic                    flag_wr;
    logic [NCH-1:0]          flag_q;
    logic [NCH-1:0][CW-1:0]  cmp_act;
    logic [NCH-1:0][CW-1:0]  cmp_shd;

    // Decode the mode into buffering and the qualified shadow-load strobe.
    always_comb begin
        mode_e      = ocu_mode_e'(mode);
        buffered    = mode_buffered(mode_e);
        load_strobe = tick_en && ((mode_e == MODE_PWM_TOP) ? at_top : at_bottom);
        flag_wr     = cpu_wr && (cpu_addr == FLAG_ADDR);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_ocu_channel #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .count      (count),
            .tick_en    (tick_en),
            .buffered   (buffered),
            .load_strobe(load_strobe),
            .wr_en      (cpu_wr && (cpu_addr == AW'(g))),
            .wr_data    (cpu_wdata),
            .sw_clr     (flag_wr && cpu_wdata[g]),
            .ack        (irq_ack[g]),
            .match      (match[g]),
            .flag       (flag_q[g]),
            .active     (cmp_act[g]),
            .shadow     (cmp_shd[g])
        );
    end

    // Gate each flag with its interrupt enable.
    always_comb begin
        irq = flag_q & irq_en;
    end

    // Read mux: the shadow while buffered, otherwise the active value; then the flags.
    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cpu_addr == AW'(i)) begin
                cpu_rdata = buffered ? cmp_shd[i] : cmp_act[i];
            end
        end
        if (cpu_addr == FLAG_ADDR) begin
            cpu_rdata[NCH-1:0] = flag_q;
        end
    end

endmodule

// File: rtl/tmr_ocu_chk.sv
// Assertion checker for tmr_ocu, attached to it by bind.
// Relates the port activity to the flag and compare state inside the top.
module tmr_ocu_chk #(
    parameter int CW  = 8,
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick_en,
    input logic [1:0]             mode,
    input logic                   cpu_wr,
    input logic [AW-1:0]          cpu_addr,
    input logic [CW-1:0]          cpu_wdata,
    input logic [NCH-1:0]         irq_en,
    input logic [NCH-1:0]         irq_ack,
    input logic [NCH-1:0]         match,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         flag_q,
    input logic [NCH-1:0][CW-1:0] cmp_act
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R2 and R6: a match on a tick leaves the flag set afterwards.
        a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_en && match[g]) |=> flag_q[g]);

        // R3: a request needs both the flag and the enable.
        a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> (flag_q[g] && irq_en[g]));

        // R4: an acknowledge with no competing set clears the flag.
        a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[g] && !(tick_en && match[g])) |=> !flag_q[g]);

        // R5: a zero bit in a flag write leaves the flag unchanged.
        a_r5_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && cpu_addr == AW'(NCH) && !cpu_wdata[g] && !irq_ack[g]
             && !(tick_en && match[g])) |=> $stable(flag_q[g]));

        // R7: in direct mode the active value changes only through a write.
        a_r7_direct_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode[1] && !(cpu_wr && cpu_addr == AW'(g))) |=> $stable(cmp_act[g]));

        // R8: in buffered mode the active value holds when there is no tick.
        a_r8_buffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[1] && !tick_en) |=> $stable(cmp_act[g]));
    end

endmodule

bind tmr_ocu tmr_ocu_chk #(.CW(CW), .NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .mode     (mode),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .irq_en   (irq_en),
    .irq_ack  (irq_ack),
    .match    (match),
    .irq      (irq),
    .flag_q   (flag_q),
    .cmp_act  (cmp_act)
);

// File: tb/tmr_ocu_tb.sv
// Self-checking bench for tmr_ocu. Sweeps every compare value against every
// count, then runs short flag and buffering sequences.
module tmr_ocu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW  = 8;
    localparam int NCH = 2;
    localparam int AW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_en = 1'b0;
    logic [CW-1:0]  count = '0;
    logic           at_top = 1'b0;
    logic           at_bottom = 1'b0;
    logic [1:0]     mode = 2'd0;
    logic           cpu_wr = 1'b0;
    logic [AW-1:0]  cpu_addr = '0;
    logic [CW-1:0]  cpu_wdata = '0;
    logic [CW-1:0]  cpu_rdata;
    logic [NCH-1:0] irq_en = '0;
    logic [NCH-1:0] irq_ack = '0;
    logic [NCH-1:0] match;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_ocu #(.CW(CW), .NCH(NCH), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count),
        .at_top(at_top), .at_bottom(at_bottom), .mode(mode),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq_en(irq_en), .irq_ack(irq_ack),
        .match(match), .irq(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Let one rising edge pass, then move a step off the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int addr, input int data);
        cpu_addr  = AW'(addr);
        cpu_wdata = CW'(data);
        cpu_wr    = 1'b1;
        step();
        cpu_wr    = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        cpu_addr = AW'(addr);
        #1;
        data = int'(cpu_rdata);
    endtask

    task automatic chk_match0(input string req, input int c, input int exp);
        count = CW'(c);
        #1;
        chk(req, int'(match[0]), exp);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int rv;
        step();
        step();
        rst_n = 1'b1;
        #1;

        // R10: everything reads zero after reset, and both compares match count 0.
        rd(0, rv); chk("R10 cmpA", rv, 0);
        rd(1, rv); chk("R10 cmpB", rv, 0);
        rd(2, rv); chk("R10 flags", rv, 0);
        chk("R10 irq", int'(irq), 0);
        chk("R10 match", int'(match), 3);

        // R1, R7: full sweep in normal mode; A=v, B=255-v.
        mode = 2'd0;
        for (int v = 0; v < 256; v++) begin
            wr(0, v);
            wr(1, 255 - v);
            for (int c = 0; c < 256; c++) begin
                count = CW'(c);
                #1;
                chk("R1/R7 matchA", int'(match[0]), (c == v) ? 1 : 0);
                chk("R1/R7 matchB", int'(match[1]), (c == 255 - v) ? 1 : 0);
                step();
            end
        end

        // R7: a direct write in clear-on-compare mode also takes effect at once.
        mode = 2'd1;
        wr(0, 33);
        rd(0, rv); chk("R7 mode1 read", rv, 33);
        chk_match0("R7 mode1 match", 33, 1);

        // R2: a match without tick_en does not set the flag.
        mode = 2'd0;
        wr(0, 10);
        wr(1, 200);
        count = 8'd10;
        step();
        rd(2, rv); chk("R2 no tick no set", rv, 0);
        tick_en = 1'b1;
        step();
        tick_en = 1'b0;
        count = 8'd0;
        rd(2, rv); chk("R2 flag set next cycle", rv, 1);

        // R3: the interrupt follows the flag and the enable.
        #1; chk("R3 irq disabled", int'(irq), 0);
        irq_en = 2'b01; #1; chk("R3 irq enabled", int'(irq), 1);
        irq_en = 2'b10; #1; chk("R3 other enable", int'(irq), 0);
        irq_en = 2'b11;

        // R5: a zero bit keeps the flag; a one bit clears it.
        wr(2, 2);
        rd(2, rv); chk("R5 zero bit keeps", rv, 1);
        wr(2, 1);
        rd(2, rv); chk("R5 one bit clears", rv, 0);
        chk("R3 irq drops", int'(irq), 0);

        // R4: an acknowledge clears the flag.
        count = 8'd10; tick_en = 1'b1; step();
        tick_en = 1'b0; count = 8'd0;
        rd(2, rv); chk("R4 flag before ack", rv, 1);
        irq_ack = 2'b01; step(); irq_ack = 2'b00;
        rd(2, rv); chk("R4 ack clears", rv, 0);

        // R6: a set on the same edge as a software clear or an ack wins.
        count = 8'd10; tick_en = 1'b1;
        wr(2, 1);
        tick_en = 1'b0; count = 8'd0;
        rd(2, rv); chk("R6 set beats write clear", rv, 1);
        count = 8'd10; tick_en = 1'b1; irq_ack = 2'b01; step();
        tick_en = 1'b0; irq_ack = 2'b00; count = 8'd0;
        rd(2, rv); chk("R6 set beats ack", rv, 1);
        rd(2, rv); chk("R9 flag word upper bits", rv & 8'hFC, 0);
        wr(2, 3);

        // R8, R9: mode 2 buffers the write and loads at bottom on a tick.
        mode = 2'd2;
        wr(0, 50);
        rd(0, rv); chk("R9 buffered read shadow", rv, 50);
        chk_match0("R8 active unchanged", 50, 0);
        chk_match0("R8 old value active", 10, 1);
        count = 8'd0;
        at_bottom = 1'b1; step(); at_bottom = 1'b0;
        chk_match0("R8 bottom without tick ignored", 50, 0);
        count = 8'd0;
        at_bottom = 1'b1; tick_en = 1'b1; step(); at_bottom = 1'b0; tick_en = 1'b0;
        chk_match0("R8 bottom load", 50, 1);
        wr(0, 60);
        count = 8'd0;
        at_top = 1'b1; tick_en = 1'b1; step(); at_top = 1'b0; tick_en = 1'b0;
        chk_match0("R8 top ignored in mode 2", 60, 0);
        chk_match0("R8 value kept in mode 2", 50, 1);

        // R8: mode 3 loads at top.
        mode = 2'd3;
        count = 8'd0;
        at_bottom = 1'b1; tick_en = 1'b1; step(); at_bottom = 1'b0; tick_en = 1'b0;
        chk_match0("R8 bottom ignored in mode 3", 60, 0);
        count = 8'd0;
        at_top = 1'b1; tick_en = 1'b1; step(); at_top = 1'b0; tick_en = 1'b0;
        chk_match0("R8 top load", 60, 1);

        // R9: the read source follows the mode.
        wr(0, 70);
        rd(0, rv); chk("R9 mode 3 read shadow", rv, 70);
        mode = 2'd0;
        rd(0, rv); chk("R9 mode 0 read active", rv, 60);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule